// File: doc/BRIEF.md
# Two-Stage Regulator Soft-Start Sequencer

This block brings up the reference DAC code of a voltage regulator after its enable input rises. It first waits a fixed delay, then raises the code by one unit on each tick from an external soft-start oscillator until the code reaches a fixed intermediate plateau. It holds at the plateau for a minimum time and until the voltage-ID code is valid and has stayed unchanged long enough to be trusted. It then latches that code as the target and steps toward it, upward or downward. After the code sits on the target for a fixed settle time, the block raises its power-ready output.

Until power-ready is high, the block ignores the low-power request and reports normal continuous-conduction operation. Dropping enable, or asserting the fault input (for example an overcurrent flag from the current monitor), sends the block back to idle with the code at zero and power-ready low. A new bring-up needs a fresh rising edge on enable.

One DAC code unit is 6.25 mV, so the plateau of 1.1 V is code 176 and a 1.5 V target is code 240. The delays are set in microseconds and converted to cycles of the system clock, whose frequency is a parameter.

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, dac_code is 0 and pwr_ready and lowpwr_mode are 0.
- R2: A bring-up starts only on a rising edge of enable while fault is low. The code stays 0 for the initial delay (1360 cycles at the default 1 MHz clock), and ss_tick pulses seen during that delay have no effect on dac_code.
- R3: During either ramp each ss_tick sample moves dac_code by exactly one unit, and dac_code never changes in a cycle without a tick. In the first ramp every tick counts.
- R4: The first ramp stops at the plateau code 176 (1.1 V in 6.25 mV units).
- R5: The code stays at the plateau for at least 85 cycles at the default clock, and until vid_valid is high with vid_code unchanged for the qualification time (500 ns, at least one cycle).
- R6: After the plateau, dac_code steps toward the latched vid_code, rising if it is above 176 and falling if it is below; if it equals 176 there is no second ramp. Changes on vid_code after latching have no effect.
- R7: pwr_ready rises exactly 85 cycles (default clock) after dac_code reaches the target, and the code then stays at the target.
- R8: lowpwr_mode is 0 while pwr_ready is low, and follows psi_req while pwr_ready is high.
- R9: One cycle after enable is low or fault is high, dac_code is 0 and pwr_ready is 0.
- R10: After an abort, keeping enable high does not restart the sequence; only a new rising edge of enable does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request; rising edge begins bring-up, low aborts |
| ss_tick | input | 1 | One-cycle step pulse from the soft-start oscillator |
| vid_code | input | CODE_W | Voltage-ID target in 6.25 mV units |
| vid_valid | input | 1 | vid_code is meaningful |
| psi_req | input | 1 | Low-power mode request |
| fault | input | 1 | Fault or overcurrent; aborts to idle |
| dac_code | output | CODE_W | Reference DAC code |
| pwr_ready | output | 1 | Bring-up complete |
| lowpwr_mode | output | 1 | Effective low-power mode (0 means continuous conduction) |

## Verification
Targets above, below and equal to the plateau are applied, so upward ramps, downward ramps and the skipped second ramp are each seen, along with the extreme code 255. A tick held high through the whole run separates a correct initial delay from one that is off by a cycle, while sparse random ticks show that the code moves only on ticks. A long late vid_valid distinguishes the validation hold from the fixed minimum, and toggling vid_code after latching shows the target is captured once. Fault pulses in mid-ramp and in the ready state, followed by a held-high enable, show the abort path and that no restart happens without a new edge.

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq #(
  parameter int unsigned CLK_HZ        = 1_000_000,
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned MID_CODE      = 176,
  parameter int unsigned INIT_US       = 1360,
  parameter int unsigned HOLD_US       = 85,
  parameter int unsigned SETTLE_US     = 85,
  parameter int unsigned VID_QUAL_NS   = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              ss_tick,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              vid_valid,
  input  logic              psi_req,
  input  logic              fault,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_ready,
  output logic              lowpwr_mode
);

  localparam longint unsigned HZ      = 64'(CLK_HZ);
  localparam longint unsigned INIT_L  = HZ * 64'(INIT_US) / 64'd1_000_000;
  localparam longint unsigned HOLD_L  = HZ * 64'(HOLD_US) / 64'd1_000_000;
  localparam longint unsigned SETL_L  = HZ * 64'(SETTLE_US) / 64'd1_000_000;
  localparam longint unsigned QUAL_L  = (HZ * 64'(VID_QUAL_NS) + 64'd999_999_999) / 64'd1_000_000_000;

  localparam int unsigned INIT_CYC = (INIT_L < 1) ? 1 : int'(INIT_L);
  localparam int unsigned HOLD_CYC = (HOLD_L < 1) ? 1 : int'(HOLD_L);
  localparam int unsigned SETL_CYC = (SETL_L < 1) ? 1 : int'(SETL_L);
  localparam int unsigned QUAL_CYC = (QUAL_L < 1) ? 1 : int'(QUAL_L);

  localparam int unsigned MAX_A   = (INIT_CYC > HOLD_CYC) ? INIT_CYC : HOLD_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > SETL_CYC) ? MAX_A : SETL_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned QUAL_W  = $clog2(QUAL_CYC + 1);

  localparam logic [CNT_W-1:0]  INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0]  SETL_LAST = CNT_W'(SETL_CYC - 1);
  localparam logic [CODE_W-1:0] MID      = CODE_W'(MID_CODE);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RISE1, S_PLAT, S_RISE2, S_SETTLE, S_READY
  } st_t;

  st_t               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] dac_q, dac_d;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic [CODE_W-1:0] vid_prev_q;
  logic [QUAL_W-1:0] qual_q, qual_d;
  logic              en_q;
  logic              abort;
  logic              vid_ok;

  assign abort  = !enable || fault;
  assign vid_ok = (qual_q == QUAL_W'(QUAL_CYC));

  always_comb begin
    if (vid_valid && vid_code == vid_prev_q)
      qual_d = vid_ok ? qual_q : qual_q + QUAL_W'(1);
    else
      qual_d = '0;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dac_d = dac_q;
    tgt_d = tgt_q;
    unique case (st_q)
      S_IDLE: begin
        dac_d = '0;
        cnt_d = '0;
        if (enable && !en_q && !fault) st_d = S_WAIT;
      end
      S_WAIT: begin
        if (cnt_q == INIT_LAST) begin
          st_d  = S_RISE1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      S_RISE1: begin
        if (ss_tick) begin
          dac_d = dac_q + ONE;
          if (dac_d == MID) begin
            st_d  = S_PLAT;
            cnt_d = '0;
          end
        end
      end
      S_PLAT: begin
        if (cnt_q != HOLD_LAST) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else if (vid_ok) begin
          tgt_d = vid_code;
          cnt_d = '0;
          st_d  = (vid_code == dac_q) ? S_SETTLE : S_RISE2;
        end
      end
      S_RISE2: begin
        if (ss_tick) begin
          dac_d = (tgt_q > dac_q) ? dac_q + ONE : dac_q - ONE;
          if (dac_d == tgt_q) st_d = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (cnt_q == SETL_LAST) st_d = S_READY;
        else cnt_d = cnt_q + CNT_W'(1);
      end
      S_READY: ;
      default: st_d = S_IDLE;
    endcase
    if (abort) begin
      st_d  = S_IDLE;
      dac_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      dac_q      <= '0;
      tgt_q      <= '0;
      vid_prev_q <= '0;
      qual_q     <= '0;
      en_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      dac_q      <= dac_d;
      tgt_q      <= tgt_d;
      vid_prev_q <= vid_code;
      qual_q     <= qual_d;
      en_q       <= enable;
    end
  end

  assign dac_code    = dac_q;
  assign pwr_ready   = (st_q == S_READY);
  assign lowpwr_mode = pwr_ready && psi_req;

  p_wait_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT) |-> (dac_code == '0));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != S_IDLE && st_q != S_IDLE) |->
      (dac_code == $past(dac_code) || dac_code == $past(dac_code) + ONE ||
       dac_code == $past(dac_code) - ONE));

  p_plateau_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PLAT) |-> (dac_code == MID));

  p_ready_on_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ready |-> (dac_code == tgt_q));

  p_ready_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ready) |-> ($past(st_q) == S_SETTLE && $past(cnt_q) == SETL_LAST));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || fault) |=> (dac_code == '0 && !pwr_ready));

endmodule

// File: tb/sim_vr_softstart_seq.sv
module sim_vr_softstart_seq;
  localparam int CLK_HZ = 1_000_000;
  localparam int MID    = 176;

  function automatic int us_cyc(int us);
    return int'((64'(CLK_HZ) * 64'(us)) / 64'd1_000_000);
  endfunction

  function automatic int step_toward(int cur, int tgt);
    if (tgt > cur) return cur + 1;
    if (tgt < cur) return cur - 1;
    return cur;
  endfunction

  localparam int D1  = 1360;
  localparam int HLD = 85;
  localparam int RDY = 85;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, ss_tick = 1'b0, vid_valid = 1'b0, psi_req = 1'b0, fault = 1'b0;
  logic [7:0] vid_code = 8'd0;
  logic [7:0] dac_code;
  logic pwr_ready, lowpwr_mode;

  int checks = 0, errors = 0;

  vr_softstart_seq u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ss_tick(ss_tick),
    .vid_code(vid_code), .vid_valid(vid_valid), .psi_req(psi_req), .fault(fault),
    .dac_code(dac_code), .pwr_ready(pwr_ready), .lowpwr_mode(lowpwr_mode)
  );

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bringup(int tgt, int pct, int vdelay);
    int n = 0, first = -1, pin = -1, pout = -1, reach = -1, rdy = -1, vstart = -1;
    int serr = 0, lerr = 0, perr = 0, exp;
    logic [7:0] pd;
    bit pt;
    @(negedge clk);
    enable = 1'b1;
    vid_valid = 1'b0;
    vid_code = 8'(tgt ^ (1 + $urandom % 255));
    ss_tick = (pct >= 100) ? 1'b1 : (($urandom % 100) < pct);
    pd = dac_code;
    pt = ss_tick;
    while (rdy < 0 && n < 30000) begin
      @(negedge clk);
      n++;
      if (dac_code != pd) begin
        if (first < 0) first = n;
        if (!pt) serr++;
        if (pin >= 0 && pout < 0) pout = n;
        exp = (pin < 0) ? int'(pd) + 1 : step_toward(int'(pd), tgt);
        if (int'(dac_code) != exp) serr++;
        if (pin < 0 && dac_code == 8'(MID)) pin = n;
        if (pin >= 0 && dac_code == 8'(tgt)) reach = n;
      end else if (pt && n > D1 + 1 && pin < 0) begin
        serr++;
      end
      if (pin >= 0 && pout < 0 && dac_code != 8'(MID)) perr++;
      if (pwr_ready && rdy < 0) rdy = n;
      if (!pwr_ready && lowpwr_mode) lerr++;
      ss_tick = (pct >= 100) ? 1'b1 : (($urandom % 100) < pct);
      psi_req = 1'($urandom);
      if (pin >= 0 && vstart < 0 && n >= pin + vdelay) vstart = n;
      if (vstart < 0) begin
        vid_valid = 1'b0;
        vid_code = 8'(tgt ^ (1 + $urandom % 255));
      end else if (reach >= 0 && tgt != MID) begin
        vid_valid = 1'b1;
        vid_code = 8'($urandom);
      end else begin
        vid_valid = 1'b1;
        vid_code = 8'(tgt);
      end
      pd = dac_code;
      pt = ss_tick;
    end
    if (pct >= 100) chk(first == D1 + 2, "R2 first step cycle", first, D1 + 2);
    else chk(first >= D1 + 2, "R2 first step not before delay", first, D1 + 2);
    chk(serr == 0, "R3 step errors", serr, 0);
    chk(pin > 0, "R4 plateau reached", pin, 1);
    chk(perr == 0, "R4 plateau code held", perr, 0);
    if (tgt != MID) begin
      chk(pout - pin >= HLD + 1, "R5 minimum hold", pout - pin, HLD + 1);
      if (pct >= 100 && vdelay > HLD + 5) chk(pout == vstart + 4, "R5 vid qualified exit", pout, vstart + 4);
      else chk(pout > vstart, "R5 exit after vid valid", pout, vstart + 1);
      chk(rdy - reach == RDY, "R7 ready delay", rdy - reach, RDY);
    end
    chk(rdy > 0 && dac_code == 8'(tgt), "R6 final code", int'(dac_code), tgt);
    chk(lerr == 0, "R8 lowpwr gated before ready", lerr, 0);
    lerr = 0; serr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lowpwr_mode != psi_req) lerr++;
      if (dac_code != 8'(tgt) || !pwr_ready) serr++;
      psi_req = 1'($urandom);
      vid_code = 8'($urandom);
    end
    chk(lerr == 0, "R8 lowpwr follows request", lerr, 0);
    chk(serr == 0, "R6 latched target kept", serr, 0);
    enable = 1'b0;
    @(negedge clk);
    chk(dac_code == 8'd0 && !pwr_ready, "R9 enable drop", int'(dac_code), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(dac_code == 8'd0 && !pwr_ready && !lowpwr_mode, "R1 reset state", int'(dac_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(us_cyc(1360) == D1 && us_cyc(85) == RDY, "R2 cycle conversion", us_cyc(1360), D1);

    bringup(240, 100, 0);
    bringup(240, 100, 300);
    bringup(MID, 50, 10);
    bringup(100, 60, 0);
    bringup(255, 100, 0);
    bringup(0, 80, 5);
    for (int r = 0; r < 6; r++)
      bringup(int'($urandom % 256), 20 + int'($urandom % 80), int'($urandom % 200));

    @(negedge clk);
    vid_code = 8'd200;
    vid_valid = 1'b1;
    enable = 1'b1;
    ss_tick = 1'b1;
    repeat (1500) @(negedge clk);
    chk(dac_code > 8'd0, "R3 mid ramp before fault", int'(dac_code), 1);
    fault = 1'b1;
    @(negedge clk);
    chk(dac_code == 8'd0 && !pwr_ready, "R9 fault abort", int'(dac_code), 0);
    fault = 1'b0;
    bad = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (dac_code != 8'd0 || pwr_ready) bad++;
    end
    chk(bad == 0, "R10 no restart without edge", bad, 0);
    enable = 1'b0;
    ss_tick = 1'b0;
    repeat (2) @(negedge clk);

    bringup(200, 100, 0);
    @(negedge clk);
    enable = 1'b1;
    ss_tick = 1'b1;
    vid_code = 8'd190;
    while (!pwr_ready) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    chk(!pwr_ready && dac_code == 8'd0, "R9 fault in ready", int'(pwr_ready), 0);
    fault = 1'b0;
    repeat (50) @(negedge clk);
    chk(dac_code == 8'd0, "R10 held enable after ready fault", int'(dac_code), 0);
    enable = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule